// File: doc/BRIEF.md
# Packed BCD to Binary Converter by Repeated Halving

The block turns a packed decimal number of `DIGITS` digits into its binary value. The decimal number is not multiplied out. It is divided by two over and over while still in decimal form. In each step the whole decimal register moves one bit to the right. Any digit that takes a bit from the digit above it is then reduced by three. That bit arrives with weight eight, but in decimal it is worth five. The bit that falls out of the lowest digit is the remainder of the step. It is the next binary result bit, starting from the least significant bit.

The block uses one halving step per clock. A conversion takes exactly `BIN_W` steps, where `BIN_W` is the smallest width that can hold every `DIGITS`-digit decimal value (14 bits for four digits). To begin, pulse `start` for one cycle while `ready` is high. `ready` stays low until the result is complete. `done` is then pulsed for one cycle. The result stays on `bin_out` until the next conversion is started.

Top module: `bcd_halving_conv`

## Requirements
- R1: While `rst_n` is low, and immediately after it, `ready` is 1, `done` is 0 and `bin_out` is 0. A reset in the middle of a conversion abandons it.
- R2: A `start` sampled high while `ready` is high loads `bcd_in` and clears the result. `ready` is low from the next cycle until the conversion ends.
- R3: `done` rises exactly `BIN_W` clock cycles after the cycle in which the start was accepted. It is high for a single cycle, and `ready` rises in that same cycle.
- R4: When `done` is high, `bin_out` equals the decimal value of the loaded input. Digit k of `bcd_in` is held in bits [4k+3:4k], with digit 0 least significant, and each digit is 0 to 9.
- R5: A `start` pulse during a conversion is ignored, whatever value is on `bcd_in`. Both the result and the completion cycle are the same as without the pulse.
- R6: After completion and without a new start, `bin_out` holds its value.
- R7: Each step strictly reduces a nonzero decimal register. This includes values in which every digit gets a bit from above, such as all nines and odd digits in every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion; honoured only while `ready` is high |
| bcd_in | input | 4*DIGITS | Packed decimal input, digit 0 in the low nibble |
| ready | output | 1 | High when idle and able to accept `start` |
| bin_out | output | BIN_W | Binary result |
| done | output | 1 | One-cycle pulse when `bin_out` holds a new result |

## Verification
An accepted start shows `ready` low one cycle later. It shows `done` high, `ready` high and the final `bin_out` exactly `BIN_W` cycles after the accepting edge, and `done` low again one cycle after that. The bench drives inputs on falling edges and counts falling edges from the start pulse. It samples at the count where each result is due. A `done` seen earlier than that count is also reported as a failure. Every four-digit value is converted, followed by seeded random values and directed runs. The directed runs cover a second start pulse during a conversion, a hold period with no start, and a reset in the middle of a conversion.

// File: rtl/bcdh_pkg.sv
package bcdh_pkg;

  // Smallest width w such that 2**w >= 10**digits.
  function automatic int unsigned bin_width(input int unsigned digits);
    longint unsigned lim;
    int unsigned     w;
    lim = 64'd1;
    for (int unsigned i = 0; i < digits; i++) lim = lim * 64'd10;
    w = 0;
    for (int k = 0; k < 63; k++) begin
      if ((64'd1 << k) < lim) w = k + 1;
    end
    return w;
  endfunction

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} conv_state_e;

endpackage

// File: rtl/bcdh_digit_fix.sv
// Corrects one digit after the register shift. If bit 3 is set, it came
// from the digit above and is worth 5, not 8.
module bcdh_digit_fix (
  input  logic [3:0] nib_in,
  output logic [3:0] nib_out
);
  always_comb begin
    if (nib_in[3]) nib_out = nib_in - 4'd3;
    else           nib_out = nib_in;
  end
endmodule

// File: rtl/bcdh_halver.sv
// Divides a packed decimal value by two in one combinational pass.
module bcdh_halver #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] val_in,
  output logic [W-1:0] half_out,
  output logic         rem_out
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = {1'b0, val_in[W-1:1]};
    rem_out = val_in[0];
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcdh_digit_fix u_fix (
      .nib_in  (shifted[4*g +: 4]),
      .nib_out (half_out[4*g +: 4])
    );
  end
endmodule

// File: rtl/bcdh_ctrl.sv
// Sequencer: idle/run state, step counter, one-cycle completion pulse.
module bcdh_ctrl #(
  parameter int STEPS = 14,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic ready,
  output logic done
);
  import bcdh_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  conv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ready = (state_q == ST_IDLE);
  assign done  = done_q;

  // R3: completion pulse lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: block is idle when the pulse is shown
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
  // R2: accepted start makes the block busy
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);
  // R5: start during a conversion neither restarts nor finishes it early
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start && cnt_q != LAST) |=> (!ready && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bcd_halving_conv.sv
module bcd_halving_conv #(
  parameter int DIGITS = 4,
  localparam int BIN_W = bcdh_pkg::bin_width(DIGITS),
  localparam int W = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     bcd_in,
  output logic             ready,
  output logic [BIN_W-1:0] bin_out,
  output logic             done
);
  logic [W-1:0]     dec_q, dec_d, dec_half;
  logic [BIN_W-1:0] res_q, res_d;
  logic             rem;
  logic             load, step, dec_en;

  bcdh_ctrl #(.STEPS(BIN_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .ready (ready),
    .done  (done)
  );

  bcdh_halver #(.DIGITS(DIGITS)) u_half (
    .val_in   (dec_q),
    .half_out (dec_half),
    .rem_out  (rem)
  );

  always_comb begin
    dec_en = load | step;
    dec_d  = dec_q;
    res_d  = res_q;
    if (load) begin
      dec_d = bcd_in;
      res_d = '0;
    end else if (step) begin
      dec_d = dec_half;
      res_d = {rem, res_q[BIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
      res_q <= '0;
    end else if (dec_en) begin
      dec_q <= dec_d;
      res_q <= res_d;
    end
  end

  assign bin_out = res_q;

  // R7: each step strictly reduces a nonzero decimal register
  p_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dec_q != '0) |=> (dec_q < $past(dec_q)));
  // R6: result is stable while idle without a new start
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(bin_out));
endmodule

// File: tb/bcd_halving_conv_test.sv
`timescale 1ns/1ps
module bcd_halving_conv_test;
  localparam int D = 4;
  localparam int N = 14;  // smallest w with 2**w >= 10**4

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [4*D-1:0] bcd_in;
  logic          ready;
  logic [N-1:0]  bin_out;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned seed;
  bit finished = 0;

  bcd_halving_conv #(.DIGITS(D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bcd_in(bcd_in),
    .ready(ready), .bin_out(bin_out), .done(done)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int value, input bit poke);
    bit early = 0;
    @(negedge clk);
    check(!done && ready, "R3 idle before start", {30'd0, done, ready}, 1);
    start  = 1'b1;
    bcd_in = to_bcd(value);
    @(negedge clk);
    start = 1'b0;
    check(!ready, "R2 busy after start", int'(ready), 0);
    for (int k = 2; k <= N + 1; k++) begin
      @(negedge clk);
      if (poke) begin
        start = (k == 4);
        if (k == 4) bcd_in = 16'h9999;
      end
      if (done && k != N + 1) early = 1;
    end
    check(done && ready && !early, poke ? "R5 timing with ignored start" : "R3 done latency",
          {29'd0, early, done, ready}, 3);
    check(int'(bin_out) == value, poke ? "R5 result with ignored start" : "R4 result",
          int'(bin_out), value);
  endtask

  initial begin
    seed   = 32'd1234;
    rst_n  = 1'b0;
    start  = 1'b0;
    bcd_in = '0;
    repeat (3) @(negedge clk);
    check(ready && !done && bin_out == 0, "R1 reset state", {ready, done, bin_out}, 32'h8000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !done && bin_out == 0, "R1 after release", {ready, done, bin_out}, 32'h8000);

    // R7 corner cases: all nines, odd digits everywhere, tens carry
    run_conv(9999, 0);
    run_conv(1111, 0);
    run_conv(10, 0);
    run_conv(0, 0);
    run_conv(8192, 0);

    // R6: result holds while idle
    repeat (6) @(negedge clk);
    check(int'(bin_out) == 8192, "R6 hold", int'(bin_out), 8192);
    check(!done, "R3 single pulse", int'(done), 0);

    // R5: start pulse mid-conversion ignored
    run_conv(4321, 1);
    run_conv(7, 1);

    // R4: exhaustive sweep
    for (int v = 0; v < 10000; v++) run_conv(v, 0);

    // R4: seeded random values
    for (int r = 0; r < 40; r++) run_conv(int'($urandom(seed) % 10000), 0);

    // R1: reset in the middle of a conversion
    @(negedge clk);
    start  = 1'b1;
    bcd_in = to_bcd(5555);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ready && !done && bin_out == 0, "R1 mid-run reset", {ready, done, bin_out}, 32'h8000);
    rst_n = 1'b1;
    run_conv(2024, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 199000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule